// File: doc/BRIEF.md
# Floating-Point Min/Max Selection Unit

This block selects the smaller or the larger of two floating-point operands. Each operand is a binary32 or a binary64 value, and a format input says which. A four-bit operation code picks the selection rule. There are four rule families, and each one differs in how it orders signed zeros and how it treats NaN operands:

- the legacy number-preferring rule;
- the NaN-propagating rule;
- the newer number-preferring rule;
- a plain C-style compare-and-pick.

Every family also has a magnitude variant. That variant compares absolute values first and falls back to its base rule on a tie or when a NaN is present.

The unit accepts one operation per clock when `in_valid` is high. It returns the selected value, plus an invalid-operation flag, exactly one clock later. The block never does arithmetic. Ordering comes from the sign-magnitude bit patterns alone: an unsigned compare of the magnitudes is resolved by the sign bits. A NaN result is always the canonical quiet NaN of the active format.

Top module: `fp_minmax_unit`

## Requirements
- R1: A result and `out_valid` appear on the clock edge after the one that samples `in_valid` high. `out_valid` is low one cycle after `in_valid` was low. A synchronous `rst` forces `out_valid` low.
- R2: `in_fmt`=1 selects binary64 on all 64 bits. `in_fmt`=0 selects binary32 in bits [31:0]; bits [63:32] of the operands are ignored and bits [63:32] of the result are zero.
- R3: The operation code is decoded as follows:
  - `in_op[0]`=1 selects max, 0 selects min.
  - `in_op[2:1]` selects the family: 00 legacy, 01 NaN-propagating, 10 number-preferring, 11 C-ternary.
  - `in_op[3]`=1 selects the magnitude variant.

  For non-NaN operands, the families 00, 01 and 10 order values numerically, with -0 strictly below +0.
- R4: C-ternary min returns A when A < B, otherwise B. C-ternary max returns A when A > B, otherwise B. Numerically equal operands (including -0 against +0) give B, and any NaN operand gives B unchanged.
- R5: The NaN-propagating family returns the canonical quiet NaN whenever either operand is a NaN.
- R6: The number-preferring family returns the non-NaN operand when exactly one operand is a NaN, and the canonical quiet NaN when both are.
- R7: The legacy family returns the canonical quiet NaN when any operand is a signaling NaN (quiet bit, the fraction MSB, clear) or when both operands are NaN. When exactly one operand is a quiet NaN, it returns the other operand.
- R8: `out_invalid` is 1 exactly when either operand is a signaling NaN, in every mode and format.
- R9: A magnitude-variant min returns A when |A| < |B| and B when |A| > |B|; a max does the opposite. On equal magnitudes, or when any operand is a NaN, the variant returns its base family's result.
- R10: The canonical quiet NaN is 0x7FC00000 for binary32 (upper half zero) and 0x7FF8000000000000 for binary64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request this cycle |
| in_fmt | input | 1 | 1 = binary64, 0 = binary32 |
| in_op | input | 4 | Operation code (magnitude, family, max) |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Selected value or canonical quiet NaN |
| out_invalid | output | 1 | A signaling NaN operand was seen |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle valid latency;
- that the invalid flag follows the signaling-NaN detection;
- that every result is either operand A, operand B or the canonical NaN;
- the B-on-NaN rule of the C-ternary family;
- the forced NaN of the propagating family.

The exact choice between the two operands depends on the family, the zero signs and the magnitude ties. That choice, and the zeroing of the upper half in binary32, can only be shown by the bench's directed corners and random operands checked against its reference model.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

   localparam int unsigned FPMM_MAG_W = 63;

   typedef enum logic [1:0] {
      FAM_LEGACY  = 2'b00,
      FAM_NANPROP = 2'b01,
      FAM_NUMBER  = 2'b10,
      FAM_CTERN   = 2'b11
   } fam_e;

   typedef struct packed {
      logic                  sign;
      logic                  nan;
      logic                  snan;
      logic                  zero;
      logic [FPMM_MAG_W-1:0] mag;
   } opnd_s;

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
   import fpmm_pkg::*;
#(
   parameter int unsigned W   = 64,
   parameter int unsigned E32 = 8,
   parameter int unsigned F32 = 23,
   parameter int unsigned E64 = 11,
   parameter int unsigned F64 = 52
) (
   input  logic         fmt64,
   input  logic [W-1:0] raw,
   output opnd_s        info,
   output logic [W-1:0] norm
);
   localparam int unsigned S32 = E32 + F32;
   localparam int unsigned S64 = E64 + F64;

   logic exp_ones;
   logic frac_nz;
   logic quiet;

   always_comb begin
      info.mag = '0;
      norm     = '0;
      if (fmt64) begin
         info.sign = raw[S64];
         exp_ones  = &raw[S64-1:F64];
         frac_nz   = |raw[F64-1:0];
         quiet     = raw[F64-1];
         info.mag  = raw[S64-1:0];
         norm      = raw;
      end else begin
         info.sign         = raw[S32];
         exp_ones          = &raw[S32-1:F32];
         frac_nz           = |raw[F32-1:0];
         quiet             = raw[F32-1];
         info.mag[S32-1:0] = raw[S32-1:0];
         norm[S32:0]       = raw[S32:0];
      end
      info.nan  = exp_ones & frac_nz;
      info.snan = exp_ones & frac_nz & ~quiet;
      info.zero = (info.mag == '0);
   end
endmodule

// File: rtl/fpmm_compare.sv
module fpmm_compare
   import fpmm_pkg::*;
(
   input  opnd_s x,
   input  opnd_s y,
   output logic  mag_lt,
   output logic  mag_gt,
   output logic  ord_lt,
   output logic  ord_gt,
   output logic  num_lt,
   output logic  num_gt
);
   logic both_zero;

   always_comb begin
      mag_lt    = x.mag < y.mag;
      mag_gt    = x.mag > y.mag;
      both_zero = x.zero & y.zero;
      if (x.sign != y.sign) begin
         ord_lt = x.sign;
         ord_gt = y.sign;
      end else begin
         ord_lt = x.sign ? mag_gt : mag_lt;
         ord_gt = x.sign ? mag_lt : mag_gt;
      end
      num_lt = ord_lt & ~both_zero;
      num_gt = ord_gt & ~both_zero;
   end
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
   import fpmm_pkg::*;
#(
   parameter int unsigned W   = 64,
   parameter int unsigned E32 = 8,
   parameter int unsigned F32 = 23,
   parameter int unsigned E64 = 11,
   parameter int unsigned F64 = 52
) (
   input  logic         fmt64,
   input  fam_e         fam,
   input  logic         is_max,
   input  logic         is_mag,
   input  opnd_s        x,
   input  opnd_s        y,
   input  logic [W-1:0] a_n,
   input  logic [W-1:0] b_n,
   input  logic         mag_lt,
   input  logic         mag_gt,
   input  logic         ord_lt,
   input  logic         ord_gt,
   input  logic         num_lt,
   input  logic         num_gt,
   output logic [W-1:0] result,
   output logic         invalid
);
   localparam logic [W-1:0] QNAN64 = W'({1'b0, {E64{1'b1}}, 1'b1, {(F64-1){1'b0}}});
   localparam logic [W-1:0] QNAN32 = W'({1'b0, {E32{1'b1}}, 1'b1, {(F32-1){1'b0}}});

   logic [W-1:0] qnan;
   logic [W-1:0] ord_pick;
   logic         any_nan;
   logic         both_nan;
   logic         any_snan;

   always_comb begin
      qnan     = fmt64 ? QNAN64 : QNAN32;
      any_nan  = x.nan | y.nan;
      both_nan = x.nan & y.nan;
      any_snan = x.snan | y.snan;
      ord_pick = (is_max ? ord_gt : ord_lt) ? a_n : b_n;
      unique case (fam)
         FAM_LEGACY: begin
            if (any_snan || both_nan) result = qnan;
            else if (x.nan)           result = b_n;
            else if (y.nan)           result = a_n;
            else                      result = ord_pick;
         end
         FAM_NANPROP: result = any_nan ? qnan : ord_pick;
         FAM_NUMBER: begin
            if (both_nan)   result = qnan;
            else if (x.nan) result = b_n;
            else if (y.nan) result = a_n;
            else            result = ord_pick;
         end
         default: begin
            if (any_nan) result = b_n;
            else         result = (is_max ? num_gt : num_lt) ? a_n : b_n;
         end
      endcase
      if (is_mag && !any_nan && (mag_lt || mag_gt))
         result = (is_max ? mag_gt : mag_lt) ? a_n : b_n;
      invalid = any_snan;
   end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
   import fpmm_pkg::*;
#(
   parameter int unsigned W   = 64,
   parameter int unsigned E32 = 8,
   parameter int unsigned F32 = 23,
   parameter int unsigned E64 = 11,
   parameter int unsigned F64 = 52
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic         in_fmt,
   input  logic [3:0]   in_op,
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   output logic         out_valid,
   output logic [W-1:0] out_result,
   output logic         out_invalid
);
   localparam int unsigned N_OPND = 2;
   localparam logic [W-1:0] QN64 = W'({1'b0, {E64{1'b1}}, 1'b1, {(F64-1){1'b0}}});
   localparam logic [W-1:0] QN32 = W'({1'b0, {E32{1'b1}}, 1'b1, {(F32-1){1'b0}}});

   if (W != 1 + E64 + F64) begin : g_bad_w
      $error("W must equal the binary64 width");
   end
   if (W - 1 != FPMM_MAG_W) begin : g_bad_mag
      $error("W does not match the package magnitude width");
   end
   if (1 + E32 + F32 > W) begin : g_bad_narrow
      $error("binary32 layout does not fit in W");
   end

   logic [W-1:0] raw  [N_OPND];
   logic [W-1:0] norm [N_OPND];
   opnd_s        info [N_OPND];

   assign raw[0] = in_a;
   assign raw[1] = in_b;

   for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
      fpmm_classify #(.W(W), .E32(E32), .F32(F32), .E64(E64), .F64(F64)) i_classify (
         .fmt64 (in_fmt),
         .raw   (raw[i]),
         .info  (info[i]),
         .norm  (norm[i])
      );
   end

   logic mag_lt, mag_gt, ord_lt, ord_gt, num_lt, num_gt;

   fpmm_compare i_compare (
      .x      (info[0]),
      .y      (info[1]),
      .mag_lt (mag_lt),
      .mag_gt (mag_gt),
      .ord_lt (ord_lt),
      .ord_gt (ord_gt),
      .num_lt (num_lt),
      .num_gt (num_gt)
   );

   logic [W-1:0] sel_result;
   logic         sel_invalid;
   fam_e         fam;

   assign fam = fam_e'(in_op[2:1]);

   fpmm_select #(.W(W), .E32(E32), .F32(F32), .E64(E64), .F64(F64)) i_select (
      .fmt64   (in_fmt),
      .fam     (fam),
      .is_max  (in_op[0]),
      .is_mag  (in_op[3]),
      .x       (info[0]),
      .y       (info[1]),
      .a_n     (norm[0]),
      .b_n     (norm[1]),
      .mag_lt  (mag_lt),
      .mag_gt  (mag_gt),
      .ord_lt  (ord_lt),
      .ord_gt  (ord_gt),
      .num_lt  (num_lt),
      .num_gt  (num_gt),
      .result  (sel_result),
      .invalid (sel_invalid)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_invalid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= sel_result;
            out_invalid <= sel_invalid;
         end
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid); // R1
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R1
   AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R1
   AST_INVALID_SNAN: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_invalid == $past(info[0].snan | info[1].snan))); // R8
   AST_RESULT_CHOICE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (out_result == $past(norm[0]) || out_result == $past(norm[1])
                    || out_result == QN64 || out_result == QN32)); // R10
   AST_CTERN_NAN_B: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op[2:1] == 2'b11 && (info[0].nan || info[1].nan))
      |=> out_result == $past(norm[1])); // R4
   AST_NANPROP_QNAN: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_op[2:1] == 2'b01 && (info[0].nan || info[1].nan))
      |=> out_result == ($past(in_fmt) ? QN64 : QN32)); // R5
endmodule

// File: tb/test_fp_minmax_unit.sv
module test_fp_minmax_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        in_fmt;
   logic [3:0]  in_op;
   logic [63:0] in_a, in_b;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_invalid;

   int total = 0;
   int fails = 0;

   always #2 clk = ~clk;

   fp_minmax_unit i_fp_minmax_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
      .out_invalid(out_invalid)
   );

   localparam logic [63:0] P32_ZERO = 64'h0;
   localparam logic [63:0] N32_ZERO = 64'h8000_0000;
   localparam logic [63:0] P64_ZERO = 64'h0;
   localparam logic [63:0] N64_ZERO = 64'h8000_0000_0000_0000;

   // Operation codes: bit3 magnitude, bits2:1 family, bit0 max (R3)
   function automatic logic [3:0] opc(bit mag, logic [1:0] fam, bit mx);
      return {mag, fam, mx};
   endfunction

   // Total-order key: negatives mirrored below positives, -0 just under +0
   function automatic logic [63:0] okey(bit s, logic [63:0] m);
      return s ? (64'h7FFF_FFFF_FFFF_FFFF - m) : (64'h8000_0000_0000_0000 + m);
   endfunction

   // Reference: returns {invalid, result}
   function automatic logic [64:0] ref_op(bit f64, logic [3:0] op, logic [63:0] a, logic [63:0] b);
      logic [63:0] av, bv, ma, mb, qn, r, ka, kb;
      bit sa, sb, an, bn, asn, bsn, mx, bothz;
      mx = op[0];
      if (f64) begin
         av = a; bv = b;
         sa = a[63]; sb = b[63];
         ma = {1'b0, a[62:0]}; mb = {1'b0, b[62:0]};
         an = ma > 64'h7FF0_0000_0000_0000; bn = mb > 64'h7FF0_0000_0000_0000;
         asn = an && !a[51]; bsn = bn && !b[51];
         qn = 64'h7FF8_0000_0000_0000;
      end else begin
         av = {32'h0, a[31:0]}; bv = {32'h0, b[31:0]};
         sa = a[31]; sb = b[31];
         ma = {33'h0, a[30:0]}; mb = {33'h0, b[30:0]};
         an = ma > 64'h7F80_0000; bn = mb > 64'h7F80_0000;
         asn = an && !a[22]; bsn = bn && !b[22];
         qn = 64'h7FC0_0000;
      end
      ka = okey(sa, ma); kb = okey(sb, mb);
      bothz = (ma == 0) && (mb == 0);
      case (op[2:1])
         2'b00: begin
            if (asn || bsn || (an && bn)) r = qn;
            else if (an) r = bv;
            else if (bn) r = av;
            else r = mx ? ((ka > kb) ? av : bv) : ((ka < kb) ? av : bv);
         end
         2'b01: begin
            if (an || bn) r = qn;
            else r = mx ? ((ka > kb) ? av : bv) : ((ka < kb) ? av : bv);
         end
         2'b10: begin
            if (an && bn) r = qn;
            else if (an) r = bv;
            else if (bn) r = av;
            else r = mx ? ((ka > kb) ? av : bv) : ((ka < kb) ? av : bv);
         end
         default: begin
            if (an || bn || bothz) r = bv;
            else r = mx ? ((ka > kb) ? av : bv) : ((ka < kb) ? av : bv);
         end
      endcase
      if (op[3] && !an && !bn && ma != mb)
         r = mx ? ((ma > mb) ? av : bv) : ((ma < mb) ? av : bv);
      return {asn | bsn, r};
   endfunction

   task automatic check(string req, logic [64:0] act, logic [64:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_op(string req, bit f64, logic [3:0] op, logic [63:0] a, logic [63:0] b);
      logic [64:0] exp;
      @(negedge clk);
      in_valid = 1'b1; in_fmt = f64; in_op = op; in_a = a; in_b = b;
      exp = ref_op(f64, op, a, b);
      @(negedge clk);
      in_valid = 1'b0;
      check(req, {out_valid, 64'h0}, {1'b1, 64'h0});
      check(req, {out_invalid, out_result}, exp);
   endtask

   // Random operand, biased to zeros, NaNs, infinities and ties
   function automatic logic [63:0] pick(bit f64, logic [63:0] other);
      logic [63:0] v;
      logic [31:0] junk;
      junk = $urandom;
      v = {$urandom, $urandom};
      case ($urandom % 9)
         0: v = 64'h0;
         1: v = f64 ? N64_ZERO : N32_ZERO;
         2: v = f64 ? {v[63], 12'hFFF, v[50:0]} : {32'h0, v[31], 9'h1FF, v[21:0]};
         3: v = f64 ? {v[63], 12'hFFE, v[50:1], 1'b1} : {32'h0, v[31], 9'h1FE, v[21:1], 1'b1};
         4: v = f64 ? {v[63], 63'h7FF0_0000_0000_0000} : {32'h0, v[31], 31'h7F80_0000};
         5: v = f64 ? {~other[63], other[62:0]} : {32'h0, ~other[31], other[30:0]};
         6: v = other;
         default: begin
            if (f64) v[62:52] = (v[62:52] == 11'h7FF) ? 11'h400 : v[62:52];
            else v[30:23] = (v[30:23] == 8'hFF) ? 8'h80 : v[30:23];
         end
      endcase
      if (!f64) v[63:32] = junk;
      return v;
   endfunction

   function automatic string fam_req(logic [3:0] op);
      if (op[3]) return "R9";
      case (op[2:1])
         2'b00: return "R7";
         2'b01: return "R5";
         2'b10: return "R6";
         default: return "R4";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1; in_valid = 1'b0; in_fmt = 1'b0; in_op = '0; in_a = '0; in_b = '0;
      repeat (3) @(negedge clk);
      check("R1", {out_valid, 64'h0}, 65'h0);
      rst = 1'b0;
      @(negedge clk);
      check("R1", {out_valid, 64'h0}, 65'h0);

      // R3: ordered families, -0 below +0
      run_op("R3", 0, opc(0, 2'b00, 0), P32_ZERO, N32_ZERO);
      run_op("R3", 0, opc(0, 2'b00, 1), N32_ZERO, P32_ZERO);
      run_op("R3", 1, opc(0, 2'b01, 0), P64_ZERO, N64_ZERO);
      run_op("R3", 1, opc(0, 2'b10, 1), N64_ZERO, P64_ZERO);
      run_op("R3", 1, opc(0, 2'b01, 0), 64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000);
      // R4: C ternary ties and NaN give B
      run_op("R4", 0, opc(0, 2'b11, 0), N32_ZERO, P32_ZERO);
      run_op("R4", 0, opc(0, 2'b11, 1), P32_ZERO, N32_ZERO);
      run_op("R4", 1, opc(0, 2'b11, 0), 64'h7FF8_0000_0000_0001, 64'h4000_0000_0000_0000);
      run_op("R4", 0, opc(0, 2'b11, 1), 64'h3F80_0000, 64'h7FC0_0000);
      // R5: NaN propagation
      run_op("R5", 0, opc(0, 2'b01, 1), 64'h7FC0_0001, 64'h3F80_0000);
      // R6: number preferred
      run_op("R6", 1, opc(0, 2'b10, 0), 64'h7FF8_0000_0000_0000, 64'hC000_0000_0000_0000);
      run_op("R6", 0, opc(0, 2'b10, 1), 64'hFFC0_0000, 64'h7FC0_1234);
      // R7 / R8: legacy with quiet and signaling NaN
      run_op("R7", 0, opc(0, 2'b00, 0), 64'h4000_0000, 64'h7FC0_0000);
      run_op("R7", 1, opc(0, 2'b00, 1), 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000);
      run_op("R8", 0, opc(0, 2'b11, 0), 64'h7F80_0001, 64'h3F80_0000);
      run_op("R8", 1, opc(1, 2'b10, 1), 64'h3FF0_0000_0000_0000, 64'hFFF4_0000_0000_0000);
      // R9: magnitude compare and tie fallback
      run_op("R9", 0, opc(1, 2'b00, 0), 64'hC000_0000, 64'h3F80_0000);
      run_op("R9", 0, opc(1, 2'b00, 1), 64'hC000_0000, 64'h3F80_0000);
      run_op("R9", 1, opc(1, 2'b01, 1), 64'hC000_0000_0000_0000, 64'h4000_0000_0000_0000);
      run_op("R9", 0, opc(1, 2'b11, 0), 64'h4000_0000, 64'hC000_0000);
      // R2 / R10: binary32 upper bits ignored, result upper half zero
      run_op("R2", 0, opc(0, 2'b10, 1), 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_4000_0000);
      run_op("R10", 0, opc(0, 2'b01, 0), 64'hFFFF_FFFF_7FC0_0000, 64'h3F80_0000);
      run_op("R10", 1, opc(0, 2'b00, 0), 64'h7FF0_0000_0000_0002, 64'h7FF0_0000_0000_0003);

      // R1: no new valid without a request
      @(negedge clk);
      check("R1", {out_valid, 64'h0}, 65'h0);

      for (int n = 0; n < 600; n++) begin
         logic [63:0] a, b;
         logic [3:0]  op;
         bit          f64;
         f64 = $urandom % 2;
         op  = 4'($urandom);
         a   = pick(f64, {$urandom, $urandom});
         b   = pick(f64, a);
         run_op(fam_req(op), f64, op, a, b);
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule